// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block turns logical integer register numbers into physical register-file indices for a processor whose integer registers form a windowed stack. Logical registers below 32 are global and map straight through. Logical registers from 32 upward belong to the running procedure's frame. That frame sits at a base position inside a circular physical stacked file of 96 entries. It has a local part followed by an output part. A contiguous rotating sub-region at the bottom of the local part can be renamed on every loop iteration, so a software-pipelined loop can use one name for a different register each time round.

The block holds the frame state: base, local size, total size, rotating size and rotation base. Four commands change that state. An allocate command sets the sizes. A call slides the frame so that the callee's first stacked register is the caller's first output register, which passes arguments without any copy. A return brings back the caller's frame from a small frame-marker stack. A rotate command steps the rotation base. The commands use the operation encoding NOP=0, ALLOC=1, CALL=2, RET=3, ROT=4.

Two read ports and one write port are translated every cycle, and the result appears one clock later. Each translated port also reports whether the access falls outside the current frame. Two request flags go to a separate save and restore engine. One asks for registers to be spilled when the registers held in the file exceed its capacity. The other asks for a fill when a return finds no saved frame.

Top module: `stk_frame_renamer`

## Requirements
- R1: A logical register below 32 is reported unchanged as the physical index, with ill low, one clock after it is presented.
- R2: A stacked logical register 32+k that is in the frame and outside the rotating region maps to physical index 32 + ((base + k) mod 96). After reset the base and all sizes are zero.
- R3: A stacked logical register 32+k with k greater than or equal to the frame size raises that port's ill output, and the port's physical index reads 0.
- R4: ALLOC (op=1) with alloc_sol ≤ alloc_sof ≤ 96 and alloc_sor ≤ alloc_sol sets the frame size, local size and rotating size, and clears the rotation base. Any other ALLOC leaves the frame unchanged.
- R5: CALL (op=2) moves the base to (base + local size) mod 96, sets the frame size to the old output size (frame size minus local size), and clears the local size, the rotating size and the rotation base. The caller's frame is pushed onto the marker stack first.
- R6: RET (op=3) with a non-empty marker stack restores the most recently pushed base, sizes and rotation base.
- R7: Inside the rotating region (k < rotating size), offset k is replaced by (k + rrb) mod rotating size before the base is added. ROT (op=4) sets rrb to (rrb − 1) mod rotating size, and has no effect when the rotating size is 0.
- R8: spill_req is high in the cycle after any command that leaves the resident count above 96. The resident count is the local sizes of all saved frames plus the current frame size. A CALL made while all 8 marker entries are used is dropped and raises spill_req for one cycle.
- R9: A RET made with an empty marker stack raises fill_req for one cycle and leaves the frame unchanged.
- R10: A translation presented in the same cycle as a command uses the frame as it was before that command.
- R11: Op codes 5 to 7 and NOP change nothing. While reset is high, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Frame command: 0 NOP, 1 ALLOC, 2 CALL, 3 RET, 4 ROT |
| alloc_sof | input | 7 | Requested frame size for ALLOC |
| alloc_sol | input | 7 | Requested local size for ALLOC |
| alloc_sor | input | 7 | Requested rotating size for ALLOC |
| rd_lreg | input | 14 | Logical register of read ports 1 and 0, 7 bits each |
| wr_lreg | input | 7 | Logical register of the write port |
| rd_phys | output | 14 | Registered physical index per read port |
| rd_ill | output | 2 | Registered out-of-frame flag per read port |
| wr_phys | output | 7 | Registered physical index of the write port |
| wr_ill | output | 1 | Registered out-of-frame flag of the write port |
| spill_req | output | 1 | Request to save registers to memory |
| fill_req | output | 1 | Request to restore a frame from memory |

## Verification
A translation and a frame command can land in the same cycle. The cases that matter are a lookup presented together with a CALL, an ALLOC, a RET or a ROT. The bench drives the register ports with names whose mapping differs before and after the command: the caller's output registers around a call, the rotating names around a rotate, and registers just past the old frame size around an allocate. The bench's model computes the expected index from the frame as it stood before the command. Any result taken from the updated frame is then reported against R10 or the command's own requirement.

// File: rtl/srfr_pkg.sv
package srfr_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ALLOC = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_ROT   = 3'd4
  } srfr_op_e;
endpackage

// File: rtl/srfr_xlate.sv
module srfr_xlate #(
  parameter int NSTATIC = 32,
  parameter int NPHYS   = 96,
  parameter int LW      = 7,
  parameter int SZW     = 7,
  parameter int PW      = 7,
  parameter int XW      = 7
) (
  input  logic [LW-1:0]  lreg,
  input  logic [PW-1:0]  bof,
  input  logic [SZW-1:0] sof,
  input  logic [SZW-1:0] sor,
  input  logic [SZW-1:0] rrb,
  output logic [XW-1:0]  phys,
  output logic           ill
);
  localparam int AW = ((LW > SZW) ? LW : SZW) + 2;

  logic [AW-1:0] l_w;
  logic [AW-1:0] off;
  logic [AW-1:0] sum;

  always_comb begin
    l_w  = AW'(lreg);
    off  = '0;
    sum  = '0;
    phys = '0;
    ill  = 1'b0;
    if (l_w < AW'(NSTATIC)) begin
      phys = XW'(lreg);
    end else begin
      off = l_w - AW'(NSTATIC);
      if (off >= AW'(sof)) begin
        ill = 1'b1;
      end else begin
        // rotating region: rename offset by the rotation base
        if (off < AW'(sor)) begin
          off = off + AW'(rrb);
          if (off >= AW'(sor)) off = off - AW'(sor);
        end
        sum = AW'(bof) + off;
        if (sum >= AW'(NPHYS)) sum = sum - AW'(NPHYS);
        phys = XW'(AW'(NSTATIC) + sum);
      end
    end
  end
endmodule

// File: rtl/srfr_marker_stack.sv
module srfr_marker_stack #(
  parameter int DEPTH = 8,
  parameter int MW    = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [MW-1:0] wdata,
  output logic [MW-1:0] top,
  output logic          full,
  output logic          empty
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [MW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;

  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);
  assign top   = mem[IW'(sp - SPW'(1))];

  always_ff @(posedge clk) begin
    if (push && !full) mem[IW'(sp)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + SPW'(1);
    end else if (pop && !empty) begin
      sp <= sp - SPW'(1);
    end
  end

  // R8
  push_full_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/srfr_frame_ctl.sv
module srfr_frame_ctl
  import srfr_pkg::*;
#(
  parameter int NPHYS = 96,
  parameter int SZW   = 7,
  parameter int PW    = 7,
  parameter int RESW  = 10,
  parameter int MW    = 35
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     op,
  input  logic [SZW-1:0] a_sof,
  input  logic [SZW-1:0] a_sol,
  input  logic [SZW-1:0] a_sor,
  input  logic           m_full,
  input  logic           m_empty,
  input  logic [MW-1:0]  m_top,
  output logic           push,
  output logic           pop,
  output logic [MW-1:0]  m_wdata,
  output logic [PW-1:0]  bof,
  output logic [SZW-1:0] sof,
  output logic [SZW-1:0] sol,
  output logic [SZW-1:0] sor,
  output logic [SZW-1:0] rrb,
  output logic           spill_req,
  output logic           fill_req
);
  localparam int BW = PW + 1;
  localparam logic [SZW-1:0] ONE = SZW'(1);

  logic [PW-1:0]   bof_n;
  logic [SZW-1:0]  sof_n, sol_n, sor_n, rrb_n;
  logic [RESW-1:0] res, res_n;
  logic            spill_n, fill_n;
  logic [BW-1:0]   bsum;
  logic            alloc_ok;

  logic [PW-1:0]  t_bof;
  logic [SZW-1:0] t_sol, t_sof, t_sor, t_rrb;

  assign {t_bof, t_sol, t_sof, t_sor, t_rrb} = m_top;
  assign m_wdata  = {bof, sol, sof, sor, rrb};
  assign alloc_ok = (a_sol <= a_sof) && (a_sof <= SZW'(NPHYS)) && (a_sor <= a_sol);

  always_comb begin
    bof_n   = bof;
    sof_n   = sof;
    sol_n   = sol;
    sor_n   = sor;
    rrb_n   = rrb;
    res_n   = res;
    push    = 1'b0;
    pop     = 1'b0;
    spill_n = 1'b0;
    fill_n  = 1'b0;
    bsum    = BW'(bof) + BW'(sol);
    case (op)
      OP_ALLOC: begin
        if (alloc_ok) begin
          sof_n = a_sof;
          sol_n = a_sol;
          sor_n = a_sor;
          rrb_n = '0;
          res_n = res - RESW'(sof) + RESW'(a_sof);
        end
      end
      OP_CALL: begin
        if (!m_full) begin
          push  = 1'b1;
          bof_n = (bsum >= BW'(NPHYS)) ? PW'(bsum - BW'(NPHYS)) : PW'(bsum);
          sof_n = sof - sol;
          sol_n = '0;
          sor_n = '0;
          rrb_n = '0;
        end else begin
          spill_n = 1'b1;
        end
      end
      OP_RET: begin
        if (!m_empty) begin
          pop   = 1'b1;
          bof_n = t_bof;
          sol_n = t_sol;
          sof_n = t_sof;
          sor_n = t_sor;
          rrb_n = t_rrb;
          res_n = res - RESW'(sof) + RESW'(t_sof) - RESW'(t_sol);
        end else begin
          fill_n = 1'b1;
        end
      end
      OP_ROT: begin
        if (sor != '0) rrb_n = (rrb == '0) ? (sor - ONE) : (rrb - ONE);
      end
      default: ;
    endcase
    if (res_n > RESW'(NPHYS)) spill_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bof       <= '0;
      sof       <= '0;
      sol       <= '0;
      sor       <= '0;
      rrb       <= '0;
      res       <= '0;
      spill_req <= 1'b0;
      fill_req  <= 1'b0;
    end else begin
      bof       <= bof_n;
      sof       <= sof_n;
      sol       <= sol_n;
      sor       <= sor_n;
      rrb       <= rrb_n;
      res       <= res_n;
      spill_req <= spill_n;
      fill_req  <= fill_n;
    end
  end

  // R4
  sizes_chk: assert property (@(posedge clk) disable iff (rst)
    (sor <= sol) && (sol <= sof) && (sof <= SZW'(NPHYS)));
  // R7
  rot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ROT && sor != '0 && rrb != '0) |=> (rrb == $past(rrb) - ONE));
  // R7
  rot_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sor != '0) |-> (rrb < sor));
  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> ($stable(bof) && $stable(sof) && $stable(sol)));
endmodule

// File: rtl/stk_frame_renamer.sv
module stk_frame_renamer #(
  parameter int NSTATIC = 32,
  parameter int NPHYS   = 96,
  parameter int DEPTH   = 8,
  parameter int NRD     = 2,
  parameter int NWR     = 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [2:0]                       op,
  input  logic [$clog2(NPHYS+1)-1:0]       alloc_sof,
  input  logic [$clog2(NPHYS+1)-1:0]       alloc_sol,
  input  logic [$clog2(NPHYS+1)-1:0]       alloc_sor,
  input  logic [NRD*$clog2(NSTATIC+NPHYS)-1:0] rd_lreg,
  input  logic [NWR*$clog2(NSTATIC+NPHYS)-1:0] wr_lreg,
  output logic [NRD*$clog2(NSTATIC+NPHYS)-1:0] rd_phys,
  output logic [NRD-1:0]                   rd_ill,
  output logic [NWR*$clog2(NSTATIC+NPHYS)-1:0] wr_phys,
  output logic [NWR-1:0]                   wr_ill,
  output logic                             spill_req,
  output logic                             fill_req
);
  localparam int LW   = $clog2(NSTATIC + NPHYS);
  localparam int XW   = LW;
  localparam int PW   = $clog2(NPHYS);
  localparam int SZW  = $clog2(NPHYS + 1);
  localparam int RESW = $clog2((DEPTH + 1) * NPHYS + 1);
  localparam int MW   = PW + 4 * SZW;
  localparam int NP   = NRD + NWR;

  logic [PW-1:0]  bof;
  logic [SZW-1:0] sof, sol, sor, rrb;
  logic           push, pop, m_full, m_empty;
  logic [MW-1:0]  m_wdata, m_top;

  logic [NP*LW-1:0] all_l;
  logic [NP*XW-1:0] phys_c, phys_q;
  logic [NP-1:0]    ill_c, ill_q;

  srfr_frame_ctl #(
    .NPHYS(NPHYS), .SZW(SZW), .PW(PW), .RESW(RESW), .MW(MW)
  ) u_ctl (
    .clk(clk), .rst(rst), .op(op),
    .a_sof(alloc_sof), .a_sol(alloc_sol), .a_sor(alloc_sor),
    .m_full(m_full), .m_empty(m_empty), .m_top(m_top),
    .push(push), .pop(pop), .m_wdata(m_wdata),
    .bof(bof), .sof(sof), .sol(sol), .sor(sor), .rrb(rrb),
    .spill_req(spill_req), .fill_req(fill_req)
  );

  srfr_marker_stack #(.DEPTH(DEPTH), .MW(MW)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wdata(m_wdata),
    .top(m_top), .full(m_full), .empty(m_empty)
  );

  assign all_l = {wr_lreg, rd_lreg};

  for (genvar p = 0; p < NP; p++) begin : g_port
    srfr_xlate #(
      .NSTATIC(NSTATIC), .NPHYS(NPHYS), .LW(LW), .SZW(SZW), .PW(PW), .XW(XW)
    ) u_xl (
      .lreg(all_l[p*LW +: LW]), .bof(bof), .sof(sof), .sor(sor), .rrb(rrb),
      .phys(phys_c[p*XW +: XW]), .ill(ill_c[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q <= '0;
      ill_q  <= '0;
    end else begin
      phys_q <= phys_c;
      ill_q  <= ill_c;
    end
  end

  assign rd_phys = phys_q[NRD*XW-1:0];
  assign wr_phys = phys_q[NP*XW-1:NRD*XW];
  assign rd_ill  = ill_q[NRD-1:0];
  assign wr_ill  = ill_q[NP-1:NRD];

  // R1
  static_map_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_lreg[LW-1:0]) < LW'(NSTATIC)))
      |-> (rd_phys[XW-1:0] == $past(rd_lreg[LW-1:0]) && !rd_ill[0]));
  // R3
  ill_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ill[0] |-> (wr_phys[XW-1:0] == '0));
endmodule

// File: tb/stk_frame_renamer_bench.sv
`timescale 1ns/1ps
module stk_frame_renamer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = 3'd0;
  logic [6:0]  alloc_sof = '0, alloc_sol = '0, alloc_sor = '0;
  logic [13:0] rd_lreg = '0;
  logic [6:0]  wr_lreg = '0;
  logic [13:0] rd_phys;
  logic [1:0]  rd_ill;
  logic [6:0]  wr_phys;
  logic [0:0]  wr_ill;
  logic        spill_req, fill_req;

  stk_frame_renamer u_stk_frame_renamer (
    .clk(clk), .rst(rst), .op(op),
    .alloc_sof(alloc_sof), .alloc_sol(alloc_sol), .alloc_sor(alloc_sor),
    .rd_lreg(rd_lreg), .wr_lreg(wr_lreg),
    .rd_phys(rd_phys), .rd_ill(rd_ill), .wr_phys(wr_phys), .wr_ill(wr_ill),
    .spill_req(spill_req), .fill_req(fill_req)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // behavioural model of the frame
  int m_bof = 0, m_sol = 0, m_sof = 0, m_sor = 0, m_rrb = 0, m_res = 0;
  int qb[$], qsl[$], qsf[$], qsr[$], qrr[$];

  function automatic int xl(int l);
    int off;
    if (l < 32) return l;
    off = l - 32;
    if (off >= m_sof) return -1;
    if (off < m_sor) off = (off + m_rrb) % m_sor;
    return 32 + (m_bof + off) % 96;
  endfunction

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(string tag, int o, int asof, int asol, int asor,
                      int l0, int l1, int l2);
    int e[3];
    int lr[3];
    bit ef, es;
    int sf, sl;
    lr[0] = l0; lr[1] = l1; lr[2] = l2;
    @(negedge clk);
    op = 3'(o); alloc_sof = 7'(asof); alloc_sol = 7'(asol); alloc_sor = 7'(asor);
    rd_lreg = {7'(l1), 7'(l0)}; wr_lreg = 7'(l2);
    for (int i = 0; i < 3; i++) e[i] = xl(lr[i]);
    ef = 0; es = 0;
    case (o)
      1: if (asol <= asof && asof <= 96 && asor <= asol) begin
           m_res = m_res - m_sof + asof;
           m_sof = asof; m_sol = asol; m_sor = asor; m_rrb = 0;
         end
      2: if (qb.size() == 8) es = 1;
         else begin
           qb.push_back(m_bof); qsl.push_back(m_sol); qsf.push_back(m_sof);
           qsr.push_back(m_sor); qrr.push_back(m_rrb);
           m_bof = (m_bof + m_sol) % 96; m_sof = m_sof - m_sol;
           m_sol = 0; m_sor = 0; m_rrb = 0;
         end
      3: if (qb.size() == 0) ef = 1;
         else begin
           sf = qsf.pop_back(); sl = qsl.pop_back();
           m_res = m_res - m_sof + sf - sl;
           m_sof = sf; m_sol = sl;
           m_bof = qb.pop_back(); m_sor = qsr.pop_back(); m_rrb = qrr.pop_back();
         end
      4: if (m_sor > 0) m_rrb = (m_rrb + m_sor - 1) % m_sor;
      default: ;
    endcase
    if (m_res > 96) es = 1;
    @(posedge clk);
    #1;
    chk({tag, " rd0 phys"}, int'(rd_phys[6:0]),  (e[0] < 0) ? 0 : e[0]);
    chk({tag, " rd0 ill"},  int'(rd_ill[0]),     (e[0] < 0) ? 1 : 0);
    chk({tag, " rd1 phys"}, int'(rd_phys[13:7]), (e[1] < 0) ? 0 : e[1]);
    chk({tag, " rd1 ill"},  int'(rd_ill[1]),     (e[1] < 0) ? 1 : 0);
    chk({tag, " wr phys"},  int'(wr_phys),       (e[2] < 0) ? 0 : e[2]);
    chk({tag, " wr ill"},   int'(wr_ill[0]),     (e[2] < 0) ? 1 : 0);
    chk("R8 spill_req", int'(spill_req), int'(es));
    chk("R9 fill_req",  int'(fill_req),  int'(ef));
  endtask

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    // R11: reset holds all outputs at zero even with live inputs
    rd_lreg = {7'd40, 7'd5}; wr_lreg = 7'd9; op = 3'd1; alloc_sof = 7'd20;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset rd_phys", int'(rd_phys), 0);
    chk("R11 reset wr_phys", int'(wr_phys), 0);
    chk("R11 reset flags", int'({spill_req, fill_req, rd_ill, wr_ill}), 0);
    @(negedge clk);
    rst = 1'b0; op = 3'd0; alloc_sof = '0;

    step("R1", 0, 0, 0, 0, 0, 5, 31);
    step("R3", 0, 0, 0, 0, 32, 127, 33);
    step("R10", 1, 20, 12, 8, 32, 51, 52);
    step("R4", 0, 0, 0, 0, 32, 51, 52);
    step("R4", 1, 10, 11, 0, 51, 43, 52);
    step("R4", 1, 97, 0, 0, 51, 43, 52);
    step("R4", 1, 20, 12, 13, 51, 40, 39);
    for (int i = 0; i < 9; i++) step("R7", 4, 0, 0, 0, 32, 39, 40);
    step("R11", 5, 0, 0, 0, 32, 39, 45);
    step("R11", 7, 0, 0, 0, 32, 39, 45);
    step("R10", 2, 0, 0, 0, 32, 44, 51);
    step("R5", 0, 0, 0, 0, 32, 39, 40);
    step("R5", 1, 16, 10, 4, 32, 39, 47);
    step("R7", 4, 0, 0, 0, 32, 35, 47);
    step("R10", 3, 0, 0, 0, 32, 35, 48);
    step("R6", 0, 0, 0, 0, 32, 39, 51);
    step("R9", 3, 0, 0, 0, 32, 39, 52);
    step("R9", 0, 0, 0, 0, 32, 39, 51);
    // deep nesting: resident count climbs past capacity, marker stack fills
    step("R8", 1, 96, 90, 0, 32, 121, 127);
    for (int i = 0; i < 9; i++) begin
      step("R8", 2, 0, 0, 0, 32, 37, 38);
      step("R2", 1, 96, 90, 0, 32, 120, 127);
    end
    for (int i = 0; i < 10; i++) step("R6", 3, 0, 0, 0, 32, 60, 127);
    for (int i = 0; i < 400; i++) begin
      int a, b, c;
      a = int'($urandom % 100);
      b = int'($urandom % (a + 1));
      c = int'($urandom % (b + 2));
      step("R2", int'($urandom % 8), a, b, c,
           int'($urandom % 128), int'($urandom % 128), int'($urandom % 128));
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule